// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins, up to 32 wide, controlled through a small register bus. Seven control registers set how each pin behaves: output data, interrupt mask, pull-up disable, function enable, function select, direction and trigger. Each of them has three addresses. The base address reads and loads the whole word. The address four bytes above it ORs the written word into the register. The address eight bytes above it clears every bit that is written as 1. A read-only pin register returns the synchronised pad levels, and a read-only flag register holds latched interrupt events.

The function, select and trigger bits together put each pin into one of three groups. A pin can be plain I/O, where direction decides whether it drives its data bit. It can be one of three alternate functions, in which case the block only reports the choice on enable lines. It can also be an interrupt input. In interrupt mode, direction chooses the polarity and trigger chooses edge or level sensitivity. Latched flags that are not masked are ORed onto one interrupt line. Flags are cleared by writing ones to the data set address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control register reads 0 except the mask register, which reads all ones. The flag register reads 0, `irq_out` is 0, `pad_oe` is 0 and `pad_pull_en` is all ones.
- R2: The register offsets are: data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70. A write to a base offset loads the register. A write to base+4 ORs the word into it. A write to base+8 clears the bits written as 1. Bits written as 0 at base+4 or base+8 are left unchanged.
- R3: A read (`bus_valid`=1, `bus_write`=0) of a base offset returns that register. A read of 0x00 returns the pin register and a read of 0x80 returns the flags. Any other offset reads 0, and `bus_rdata` is 0 when no read is requested.
- R4: The pin register shows `pad_in` after a two-flop synchroniser. A pad change is visible after two rising clock edges, whatever the pin mode.
- R5: A pin with function=0, select=0 and trigger=0 is plain I/O. In that mode `pad_oe` equals its direction bit and `pad_out` equals its data bit. In every other mode both are 0.
- R6: With function=1, select=0 gives `alt1_en`. Select=1 with trigger=0 gives `alt2_en`, and select=1 with trigger=1 gives `alt3_en`. At most one of the three is set per pin.
- R7: `pad_pull_en` is the inverse of the pull register: a pull bit of 1 disables the pull-up.
- R8: A pin with function=0 and select=1 is an interrupt input. With trigger=1 it is edge-sensitive: direction=1 means rising and direction=0 means falling. The flag is set on the third rising edge after the pad changes.
- R9: With trigger=0 the interrupt pin is level-sensitive: direction=1 means high and direction=0 means low. The flag is set while the level is present and stays set after the level goes away.
- R10: A write to 0x14 clears the flag bits written as 1. A flag that is being set in the same cycle stays set. Nothing else clears a flag.
- R11: `irq_out` is 1 exactly when some flag bit is set and its mask bit is 0.
- R12: A pin that is not in interrupt mode never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Output data for I/O-mode pins |
| pad_oe | output | NPINS | Output enable for I/O-mode pins |
| pad_pull_en | output | NPINS | Pull-up enable |
| alt1_en | output | NPINS | Alternate function 1 selected |
| alt2_en | output | NPINS | Alternate function 2 selected |
| alt3_en | output | NPINS | Alternate function 3 selected |
| irq_out | output | 1 | Bank interrupt |

## Verification
The register walk loads, sets and clears overlapping bit patterns. This separates an OR from a load and a masked clear from a plain clear. Mode decoding is checked with function, select and trigger combinations, so a pin that is direction-enabled but in an alternate mode can be told apart from a true output. Interrupts are tried with rising and falling edges, a high level that stays asserted across a clear write, and a pad toggling on a non-interrupt pin. These tell edge from level behaviour, set priority from clear priority, and mode gating from a missing flag. Checks taken one cycle before and one cycle on the expected latch edge pin down the synchroniser latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   typedef enum logic [2:0] {
      RID_DATA = 3'd0,
      RID_MASK = 3'd1,
      RID_PULL = 3'd2,
      RID_FUNC = 3'd3,
      RID_SEL  = 3'd4,
      RID_DIR  = 3'd5,
      RID_TRIG = 3'd6
   } reg_id_e;

   localparam int NUM_CTL = 7;

   // low address nibble picks load / set / clear access
   localparam logic [3:0] SUB_LOAD = 4'h0;
   localparam logic [3:0] SUB_SET  = 4'h4;
   localparam logic [3:0] SUB_CLR  = 4'h8;

   localparam logic [7:0] OFF_PIN  = 8'h00;
   localparam logic [7:0] OFF_FLAG = 8'h80;

   function automatic logic [7:0] ctl_base(int id);
      return 8'((id + 1) * 16);
   endfunction
endpackage

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [AW-1:0]                    wr_addr,
   input  logic [NPINS-1:0]                 wr_data,
   output logic [NUM_CTL-1:0][NPINS-1:0]    ctl_q,
   output logic                             flag_clr_stb
);
   localparam logic [AW-1:0] FLAG_CLR_ADDR =
      AW'(ctl_base(int'(RID_DATA))) | AW'(SUB_SET);

   for (genvar g = 0; g < NUM_CTL; g++) begin : g_reg
      localparam logic [NPINS-1:0] RST_VAL = (g == int'(RID_MASK)) ? '1 : '0;
      logic [NPINS-1:0] q;
      logic             hit;

      assign hit = wr_en && (wr_addr[AW-1:4] == (AW-4)'(g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_VAL;
         end else if (hit) begin
            case (wr_addr[3:0])
               SUB_LOAD: q <= wr_data;
               SUB_SET:  q <= q | wr_data;
               SUB_CLR:  q <= q & ~wr_data;
               default:  q <= q;
            endcase
         end
      end

      assign ctl_q[g] = q;
   end

   assign flag_clr_stb = wr_en && (wr_addr == FLAG_CLR_ADDR);
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode #(
   parameter int NPINS = 32
) (
   input  logic [NPINS-1:0] func_q,
   input  logic [NPINS-1:0] sel_q,
   input  logic [NPINS-1:0] trig_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] oe,
   output logic [NPINS-1:0] dout,
   output logic [NPINS-1:0] alt1,
   output logic [NPINS-1:0] alt2,
   output logic [NPINS-1:0] alt3,
   output logic [NPINS-1:0] irq_en
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic plain_io;
      assign plain_io  = !func_q[p] && !sel_q[p] && !trig_q[p];
      assign oe[p]     = plain_io && dir_q[p];
      assign dout[p]   = plain_io && data_q[p];
      assign alt1[p]   = func_q[p] && !sel_q[p];
      assign alt2[p]   = func_q[p] && sel_q[p] && !trig_q[p];
      assign alt3[p]   = func_q[p] && sel_q[p] && trig_q[p];
      assign irq_en[p] = !func_q[p] && sel_q[p];
   end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_in,
   input  logic [NPINS-1:0] irq_en,
   input  logic [NPINS-1:0] edge_mode,
   input  logic [NPINS-1:0] polarity,
   input  logic             clr_stb,
   input  logic [NPINS-1:0] clr_bits,
   output logic [NPINS-1:0] pin_lvl,
   output logic [NPINS-1:0] flags
);
   logic [SYNC_STAGES-1:0][NPINS-1:0] stg;
   logic [NPINS-1:0] prev;
   logic [NPINS-1:0] edge_hit, level_hit, set_bits, clr_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         prev <= '0;
      end else begin
         stg[0] <= pad_in;
         for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
         prev <= stg[SYNC_STAGES-1];
      end
   end

   assign pin_lvl   = stg[SYNC_STAGES-1];
   assign edge_hit  = (polarity & pin_lvl & ~prev) | (~polarity & ~pin_lvl & prev);
   assign level_hit = ~(pin_lvl ^ polarity);
   assign set_bits  = irq_en & ((edge_mode & edge_hit) | (~edge_mode & level_hit));
   assign clr_eff   = clr_stb ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_eff) | set_bits;
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_valid,
   input  logic             bus_write,
   input  logic [AW-1:0]    bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_pull_en,
   output logic [NPINS-1:0] alt1_en,
   output logic [NPINS-1:0] alt2_en,
   output logic [NPINS-1:0] alt3_en,
   output logic             irq_out
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("NPINS must be 1..32");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   localparam logic [AW-1:0] PIN_ADDR  = AW'(OFF_PIN);
   localparam logic [AW-1:0] FLAG_ADDR = AW'(OFF_FLAG);

   logic [NUM_CTL-1:0][NPINS-1:0] ctl_q;
   logic                          flag_clr_stb;
   logic [NPINS-1:0]              irq_en, pin_lvl, flags;

   gpio_ctl_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (bus_valid && bus_write),
      .wr_addr      (bus_addr),
      .wr_data      (bus_wdata),
      .ctl_q        (ctl_q),
      .flag_clr_stb (flag_clr_stb)
   );

   gpio_pin_mode #(.NPINS(NPINS)) u_mode (
      .func_q (ctl_q[RID_FUNC]),
      .sel_q  (ctl_q[RID_SEL]),
      .trig_q (ctl_q[RID_TRIG]),
      .dir_q  (ctl_q[RID_DIR]),
      .data_q (ctl_q[RID_DATA]),
      .oe     (pad_oe),
      .dout   (pad_out),
      .alt1   (alt1_en),
      .alt2   (alt2_en),
      .alt3   (alt3_en),
      .irq_en (irq_en)
   );

   gpio_irq_detect #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_in    (pad_in),
      .irq_en    (irq_en),
      .edge_mode (ctl_q[RID_TRIG]),
      .polarity  (ctl_q[RID_DIR]),
      .clr_stb   (flag_clr_stb),
      .clr_bits  (bus_wdata),
      .pin_lvl   (pin_lvl),
      .flags     (flags)
   );

   assign pad_pull_en = ~ctl_q[RID_PULL];
   assign irq_out     = |(flags & ~ctl_q[RID_MASK]);

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write) begin
         if (bus_addr == PIN_ADDR) begin
            bus_rdata = pin_lvl;
         end else if (bus_addr == FLAG_ADDR) begin
            bus_rdata = flags;
         end else begin
            for (int i = 0; i < NUM_CTL; i++) begin
               if (bus_addr == AW'(ctl_base(i))) bus_rdata = ctl_q[i];
            end
         end
      end
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_valid,
   input logic                          bus_write,
   input logic [AW-1:0]                 bus_addr,
   input logic [NPINS-1:0]              bus_wdata,
   input logic [NUM_CTL-1:0][NPINS-1:0] ctl_q,
   input logic [NPINS-1:0]              flags,
   input logic [NPINS-1:0]              pad_oe,
   input logic [NPINS-1:0]              alt1_en,
   input logic [NPINS-1:0]              alt2_en,
   input logic [NPINS-1:0]              alt3_en,
   input logic                          irq_out
);
   logic [NPINS-1:0] clr_mask, irq_mode;
   assign clr_mask = (bus_valid && bus_write && bus_addr == AW'(8'h14)) ? bus_wdata : '0;
   assign irq_mode = ~ctl_q[RID_FUNC] & ctl_q[RID_SEL];

   assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (ctl_q[RID_MASK] == '1 && flags == '0 && !irq_out));

   assert_oe_io_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & (ctl_q[RID_FUNC] | ctl_q[RID_SEL] | ctl_q[RID_TRIG])) == '0);

   assert_alt_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones((alt1_en & alt2_en) | (alt1_en & alt3_en) | (alt2_en & alt3_en)) == 0);

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flags) & ~$past(clr_mask)) & ~flags) == '0);

   assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (flags != '0));

   assert_flag_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~$past(flags) & ~$past(irq_mode)) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ctl_q     (ctl_q),
   .flags     (flags),
   .pad_oe    (pad_oe),
   .alt1_en   (alt1_en),
   .alt2_en   (alt2_en),
   .alt3_en   (alt3_en),
   .irq_out   (irq_out)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
   localparam int NP = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [NP-1:0] bus_wdata = '0, bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_pull_en, alt1_en, alt2_en, alt3_en;
   logic          irq_out;

   int n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   gpio_bank #(.NPINS(NP), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pull_en(pad_pull_en), .alt1_en(alt1_en), .alt2_en(alt2_en),
      .alt3_en(alt3_en), .irq_out(irq_out)
   );

   typedef struct packed {
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [0:NV-1] = '{
      '{8'h10, 32'hA5A5_0000, 8'h10, 32'hA5A5_0000},
      '{8'h14, 32'h0000_00FF, 8'h10, 32'hA5A5_00FF},
      '{8'h18, 32'hA000_000F, 8'h10, 32'h05A5_00F0},
      '{8'h28, 32'hFFFF_0000, 8'h20, 32'h0000_FFFF},
      '{8'h24, 32'h0001_0000, 8'h20, 32'h0001_FFFF},
      '{8'h34, 32'h0000_F0F0, 8'h30, 32'h0000_F0F0},
      '{8'h44, 32'h0000_000F, 8'h40, 32'h0000_000F},
      '{8'h74, 32'h8000_0000, 8'h70, 32'h8000_0000},
      '{8'h60, 32'h1234_567F, 8'h60, 32'h1234_567F},
      '{8'h68, 32'h0000_0008, 8'h60, 32'h1234_5677},
      '{8'h78, 32'hFFFF_FFFF, 8'h70, 32'h0000_0000},
      '{8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(10 * 100000);
      n_bad++;
      $display("FAIL WDOG act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(8'h20, r); check("R1 mask reset", r, 32'hFFFF_FFFF);
      rd(8'h10, r); check("R1 data reset", r, 32'h0);
      rd(8'h80, r); check("R1 flag reset", r, 32'h0);
      check("R1 oe reset", pad_oe, 32'h0);
      check("R1 irq reset", {31'h0, irq_out}, 32'h0);
      check("R7 pull reset", pad_pull_en, 32'hFFFF_FFFF);
      rd(8'h84, r); check("R3 undefined offset", r, 32'h0);
      check("R3 idle rdata", bus_rdata, 32'h0);

      // register walk (R2)
      for (int i = 0; i < NV; i++) begin
         wr(VECS[i].waddr, VECS[i].wdata);
         rd(VECS[i].raddr, r);
         check($sformatf("R2 vec %0d", i), r, VECS[i].exp);
      end
      check("R5 oe io only", pad_oe, 32'h1234_5670);
      check("R5 out io only", pad_out, 32'h05A5_00F0);
      check("R7 pull inverted", pad_pull_en, 32'hFFFF_0F0F);
      check("R6 alt1", alt1_en, 32'h0000_000F);

      // alternate 2 and 3
      wr(8'h54, 32'h3);
      wr(8'h74, 32'h1);
      check("R6 alt1 after sel", alt1_en, 32'h0000_000C);
      check("R6 alt2", alt2_en, 32'h0000_0002);
      check("R6 alt3", alt3_en, 32'h0000_0001);

      // pin register on an I/O pin, no flag (R4, R12)
      pad_in[12] = 1'b1;
      edges(2);
      rd(8'h00, r); check("R4 pin sample", r, 32'h0000_1000);
      edges(2);
      rd(8'h80, r); check("R12 no flag io pin", r, 32'h0);

      // rising edge on pin 5
      wr(8'h64, 32'h20); wr(8'h74, 32'h20); wr(8'h54, 32'h20);
      check("R5 oe off in irq mode", pad_oe & 32'h20, 32'h0);
      rd(8'h80, r); check("R8 no flag before edge", r, 32'h0);
      pad_in[5] = 1'b1;
      edges(2);
      rd(8'h00, r); check("R4 pin after two edges", r & 32'h20, 32'h20);
      rd(8'h80, r); check("R8 flag not yet", r, 32'h0);
      edges(1);
      rd(8'h80, r); check("R8 rising flag", r, 32'h20);
      check("R11 masked irq", {31'h0, irq_out}, 32'h0);
      wr(8'h28, 32'h20);
      check("R11 unmasked irq", {31'h0, irq_out}, 32'h1);
      wr(8'h24, 32'h20);
      check("R11 remasked irq", {31'h0, irq_out}, 32'h0);
      wr(8'h28, 32'h20);
      edges(3);
      rd(8'h80, r); check("R8 edge does not repeat", r, 32'h20);
      wr(8'h14, 32'h20);
      rd(8'h80, r); check("R10 clear edge flag", r, 32'h0);
      check("R11 irq cleared", {31'h0, irq_out}, 32'h0);

      // falling edge on pin 5
      wr(8'h68, 32'h20);
      edges(3);
      rd(8'h80, r); check("R8 no flag on polarity change", r, 32'h0);
      pad_in[5] = 1'b0;
      edges(3);
      rd(8'h80, r); check("R8 falling flag", r, 32'h20);
      wr(8'h14, 32'h20);

      // level high on pin 9
      wr(8'h64, 32'h200); wr(8'h78, 32'h200); wr(8'h28, 32'h200); wr(8'h54, 32'h200);
      edges(3);
      rd(8'h80, r); check("R9 no flag while low", r, 32'h0);
      pad_in[9] = 1'b1;
      edges(3);
      rd(8'h80, r); check("R9 level flag", r, 32'h200);
      check("R11 level irq", {31'h0, irq_out}, 32'h1);
      wr(8'h14, 32'h200);
      rd(8'h80, r); check("R10 set wins over clear", r, 32'h200);
      pad_in[9] = 1'b0;
      edges(3);
      rd(8'h80, r); check("R9 flag held after level", r, 32'h200);
      wr(8'h14, 32'h200);
      rd(8'h80, r); check("R10 level flag cleared", r, 32'h0);
      wr(8'h18, 32'h200);
      rd(8'h80, r); check("R10 data clear leaves flags", r, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule